// File: doc/BRIEF.md
# E1 Receive Reframe Supervisor

This block watches the alignment state of an E1 receive framer and decides when the framer must drop its current alignment and hunt again. Its only time base is a strobe that pulses once per 125 us frame. Three causes can ask for a new search.

The first cause is a software control bit. It acts only when it goes from high to low, and only after it has stayed high across at least one frame strobe. The other two causes act only while maintenance supervision is enabled. One is a timeout: CRC multiframe lock is not reached within 8 ms of gaining frame lock. The other is an error threshold: more than the allowed number of CRC errors arrive within one second.

Any accepted cause produces a single-clock reframe request. The request clears the one-second error count and stops the lock timer. The current error count is visible at all times. The framer itself and the CRC-4 arithmetic live elsewhere.

Top module: `e1_reframe_supervisor`

## Requirements
- R1: During and right after a synchronous active-high reset, `reframe_req` is 0 and `err_count` is 0.
- R2: When `sw_reframe` has been high during at least one `frame_tick` and then goes low, `reframe_req` pulses for one clock on the clock after the first low cycle is sampled.
- R3: A high period of `sw_reframe` that sees no `frame_tick` gives no request when it ends. A steady low level gives no request.
- R4: With `maint_en` high, a rising edge of `frame_lock` starts a timer of `LOCK_FRAMES` (default 64) frame strobes. If `mf_lock` is still low on the 64th strobe after that edge, a request follows on the next clock.
- R5: The timer is cancelled, with no request, if `mf_lock` rises or `frame_lock` falls before it expires. A later rising edge of `frame_lock` restarts the count from zero.
- R6: Each `crc_err` pulse adds one to `err_count`. With `maint_en` high, the error that would take the count above `ERR_LIMIT` (default 914, so the 915th error) causes a request on the next clock.
- R7: The error count restarts every `WINDOW_FRAMES` (default 8000) frame strobes. An error that arrives in the same cycle as the window-closing strobe is counted as the first error of the new window, so `err_count` becomes 1.
- R8: With `maint_en` low, neither the timeout nor the error threshold gives a request, and `err_count` saturates at its all-ones value (1023 by default) instead of wrapping.
- R9: Every request sets `err_count` to 0 and stops the timer. A further timeout needs a new rising edge of `frame_lock`.
- R10: `reframe_req` is never high in two consecutive clocks. Causes that coincide in one cycle give a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-clock strobe per 125 us frame |
| frame_lock | input | 1 | Frame alignment found |
| mf_lock | input | 1 | CRC multiframe alignment found |
| crc_err | input | 1 | One-clock pulse per errored CRC submultiframe |
| maint_en | input | 1 | Enables the timeout and threshold causes |
| sw_reframe | input | 1 | Software reframe bit, acts on its falling edge |
| reframe_req | output | 1 | One-clock reframe request |
| err_count | output | ERR_W | Errors counted in the current one-second window |

## Verification
Two pairs of events can land in the same cycle, and both are tested. In the first, a CRC error arrives on the strobe that closes the one-second window. After five earlier errors and 7999 strobes, the bench drives the error and the final strobe together and expects `err_count` to read 1, not 6 and not 0. In the second, the software bit is released in the same cycle as the 915th error. The bench counts the request pulses and expects exactly one, with the error count cleared.

// File: rtl/e1_reframe_supervisor.sv
module e1_reframe_supervisor #(
  parameter int LOCK_FRAMES   = 64,
  parameter int WINDOW_FRAMES = 8000,
  parameter int ERR_LIMIT     = 914,
  parameter int ERR_W         = $clog2(ERR_LIMIT + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_tick,
  input  logic             frame_lock,
  input  logic             mf_lock,
  input  logic             crc_err,
  input  logic             maint_en,
  input  logic             sw_reframe,
  output logic             reframe_req,
  output logic [ERR_W-1:0] err_count
);
  localparam int TMR_W = $clog2(LOCK_FRAMES + 1);
  localparam int WIN_W = $clog2(WINDOW_FRAMES + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
  localparam logic [ERR_W-1:0] ERR_TOP = ERR_W'(ERR_LIMIT);
  localparam logic [TMR_W-1:0] TMR_END = TMR_W'(LOCK_FRAMES - 1);
  localparam logic [WIN_W-1:0] WIN_END = WIN_W'(WINDOW_FRAMES - 1);

  logic             sw_armed;
  logic             lock_q;
  logic             tmr_run;
  logic [TMR_W-1:0] tmr;
  logic [WIN_W-1:0] win;

  wire lock_rise = frame_lock & ~lock_q;
  wire win_end   = frame_tick & (win == WIN_END);
  wire sw_fire   = sw_armed & ~sw_reframe;
  wire tmo       = tmr_run & frame_lock & ~mf_lock & frame_tick & (tmr == TMR_END);
  wire over      = crc_err & ~win_end & (err_count == ERR_TOP);
  wire trigger   = sw_fire | (maint_en & (tmo | over));

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_armed <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      sw_armed <= sw_reframe & (sw_armed | frame_tick);
      lock_q   <= frame_lock;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_run <= 1'b0;
      tmr     <= '0;
    end else if (trigger) begin
      tmr_run <= 1'b0;
      tmr     <= '0;
    end else if (lock_rise) begin
      tmr_run <= 1'b1;
      tmr     <= '0;
    end else if (tmr_run && (!frame_lock || mf_lock)) begin
      tmr_run <= 1'b0;
    end else if (tmr_run && frame_tick) begin
      if (tmr == TMR_END) tmr_run <= 1'b0;
      else                tmr     <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             win <= '0;
    else if (win_end)    win <= '0;
    else if (frame_tick) win <= win + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || trigger)                    err_count <= '0;
    else if (win_end)                      err_count <= {{(ERR_W-1){1'b0}}, crc_err};
    else if (crc_err && err_count != ERR_MAX) err_count <= err_count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) reframe_req <= 1'b0;
    else     reframe_req <= trigger & ~reframe_req;
  end
endmodule

module e1_reframe_supervisor_chk #(
  parameter int ERR_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             crc_err,
  input logic             maint_en,
  input logic             sw_reframe,
  input logic             reframe_req,
  input logic [ERR_W-1:0] err_count
);
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reframe_req |=> !reframe_req);

  // R9
  clear_on_req_chk: assert property (@(posedge clk) disable iff (rst)
    reframe_req |-> err_count == '0);

  // R6
  no_spurious_count_chk: assert property (@(posedge clk) disable iff (rst)
    !crc_err |=> (err_count == $past(err_count)) || (err_count == '0));

  // R3
  steady_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!maint_en && !sw_reframe && $past(!sw_reframe)) |=> !reframe_req);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!reframe_req && err_count == '0));
endmodule

bind e1_reframe_supervisor e1_reframe_supervisor_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .crc_err(crc_err), .maint_en(maint_en),
  .sw_reframe(sw_reframe), .reframe_req(reframe_req), .err_count(err_count)
);

// File: tb/e1_reframe_supervisor_bench.sv
module e1_reframe_supervisor_bench;
  localparam int ERR_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 1'b0, frame_lock = 1'b0, mf_lock = 1'b0;
  logic crc_err = 1'b0, maint_en = 1'b0, sw_reframe = 1'b0;
  logic reframe_req;
  logic [ERR_W-1:0] err_count;

  int checks = 0, fails = 0, pulses = 0, cycles = 0;

  always #10 clk = ~clk;

  e1_reframe_supervisor u_e1_reframe_supervisor (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .frame_lock(frame_lock),
    .mf_lock(mf_lock), .crc_err(crc_err), .maint_en(maint_en),
    .sw_reframe(sw_reframe), .reframe_req(reframe_req), .err_count(err_count)
  );

  always @(negedge clk) begin
    cycles++;
    if (reframe_req) pulses++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; frame_tick = 0; frame_lock = 0; mf_lock = 0;
    crc_err = 0; maint_en = 0; sw_reframe = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1 pulses = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      frame_tick = 1'b1;
      @(negedge clk);
    end
    frame_tick = 1'b0;
  endtask

  task automatic errs(input int n);
    for (int i = 0; i < n; i++) begin
      crc_err = 1'b1;
      @(negedge clk);
    end
    crc_err = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 req after reset", reframe_req, 0);
    chk("R1 count after reset", err_count, 0);
  endtask

  task automatic t_sw_edge();
    do_reset();
    sw_reframe = 1; frame_tick = 1;
    @(negedge clk);
    frame_tick = 0;
    repeat (3) @(negedge clk);
    chk("R2 no req while high", reframe_req, 0);
    sw_reframe = 0;
    @(negedge clk);
    chk("R2 req after falling edge", reframe_req, 1);
    @(negedge clk);
    chk("R2 pulse one clock", reframe_req, 0);
    repeat (5) @(negedge clk);
    #1 chk("R2 single pulse", pulses, 1);
  endtask

  task automatic t_sw_short();
    do_reset();
    sw_reframe = 1;
    repeat (5) @(negedge clk);
    sw_reframe = 0;
    repeat (20) @(negedge clk);
    #1 chk("R3 no req without a frame", pulses, 0);
  endtask

  task automatic t_timeout();
    do_reset();
    maint_en = 1; frame_lock = 1;
    @(negedge clk);
    ticks(63);
    #1 chk("R4 quiet before expiry", pulses, 0);
    ticks(1);
    chk("R4 req on 64th frame", reframe_req, 1);
    ticks(70);
    #1 chk("R9 no second timeout", pulses, 1);
  endtask

  task automatic t_cancel();
    do_reset();
    maint_en = 1; frame_lock = 1;
    @(negedge clk);
    ticks(30);
    mf_lock = 1;
    ticks(50);
    #1 chk("R5 multiframe lock cancels", pulses, 0);
    mf_lock = 0; frame_lock = 0;
    @(negedge clk);
    frame_lock = 1;
    @(negedge clk);
    ticks(30);
    frame_lock = 0;
    ticks(50);
    #1 chk("R5 lock loss cancels", pulses, 0);
    frame_lock = 1;
    @(negedge clk);
    ticks(63);
    #1 chk("R5 restart quiet at 63", pulses, 0);
    ticks(1);
    chk("R5 restart expires at 64", reframe_req, 1);
  endtask

  task automatic t_threshold();
    do_reset();
    maint_en = 1;
    errs(914);
    chk("R6 count at limit", err_count, 914);
    #1 chk("R6 no req at limit", pulses, 0);
    errs(1);
    chk("R6 req on excess error", reframe_req, 1);
    chk("R9 count cleared", err_count, 0);
  endtask

  task automatic t_window();
    do_reset();
    errs(5);
    ticks(7999);
    chk("R7 count held in window", err_count, 5);
    frame_tick = 1; crc_err = 1;
    @(negedge clk);
    frame_tick = 0; crc_err = 0;
    chk("R7 boundary error counted in new window", err_count, 1);
  endtask

  task automatic t_maint_off();
    do_reset();
    frame_lock = 1;
    @(negedge clk);
    ticks(100);
    errs(1100);
    chk("R8 saturated count", err_count, 1023);
    #1 chk("R8 no req with maintenance off", pulses, 0);
  endtask

  task automatic t_collide();
    do_reset();
    maint_en = 1; sw_reframe = 1; frame_tick = 1;
    @(negedge clk);
    frame_tick = 0;
    errs(914);
    sw_reframe = 0; crc_err = 1;
    @(negedge clk);
    crc_err = 0;
    chk("R10 coincident causes fire", reframe_req, 1);
    repeat (5) @(negedge clk);
    #1 chk("R10 exactly one pulse", pulses, 1);
    chk("R10 count cleared", err_count, 0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_sw_edge();
        t_sw_short();
        t_timeout();
        t_cancel();
        t_threshold();
        t_window();
        t_maint_off();
        t_collide();
      end
      begin
        wait (cycles >= 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule